// File: doc/BRIEF.md
# Dual-Port Display Store Queue

This block sits at the output side of a two-pipe processor and receives stores to a small set of memory-mapped display registers. Each issue pipe can present one store per cycle, and both may target the same display in that cycle. Every display has its own queue of pending writes, so traffic to one display never delays or reorders traffic to another.

When both pipes store in the same cycle, the pipe A store is queued ahead of the pipe B store. Each queue moves its oldest entry into the display register once per cycle. A read names a display and returns the newest value written to it. If writes are still waiting in that display's queue, the newest queued value is returned. Otherwise the display register itself is returned.

A single stall output tells both pipes to hold their stores when any queue lacks room for two more entries. Stores presented while the stall is high are dropped.

Top module: `mmio_store_queue`

## Requirements
- R1: A store from only one pipe enqueues exactly that store. After the capturing edge, a read of the target display returns its data. At the following edge the display output takes that data.
- R2: When both pipes store to the same display in one cycle, both are accepted. The display output shows pipe A's data at the second edge and pipe B's data at the third edge. A read returns pipe B's data from the first edge on.
- R3: While a display's queue is non-empty, exactly one entry leaves it per cycle, oldest first, into the display output. An empty queue leaves its display output unchanged.
- R4: A read of display `rd_dev_i` returns, combinationally, the youngest queued entry for that display if its queue is non-empty, and otherwise that display's output value.
- R5: A store to one display changes neither the queue contents nor the output of any other display.
- R6: `full_o` is high exactly when some queue holds more than DEPTH-2 entries (more than 2 for the default depth of 4). No queue ever holds more than DEPTH entries.
- R7: Stores presented while `full_o` is high are dropped for every display. This holds even for displays whose own queue has room.
- R8: After reset, all queues are empty, every display output is zero, and `full_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_a_valid_i | input | 1 | Pipe A store valid |
| st_a_dev_i | input | DEV_W | Pipe A target display index |
| st_a_data_i | input | DATA_W | Pipe A store data |
| st_b_valid_i | input | 1 | Pipe B store valid |
| st_b_dev_i | input | DEV_W | Pipe B target display index |
| st_b_data_i | input | DATA_W | Pipe B store data |
| rd_dev_i | input | DEV_W | Display index to read |
| rd_data_o | output | DATA_W | Newest value written to the selected display |
| full_o | output | 1 | Stall request to both store pipes |
| dev_data_o | output | NUM_DEV*DATA_W | Display register values, display 0 in the low bits |

## Verification
Some internal faults stay hidden for a while, and others show at once. A wrong write pointer or a swapped slot order shows on `rd_data_o` right after the capturing edge. It then reaches `dev_data_o` one or two edges later, as values arriving in the wrong sequence. A wrong occupancy count shows first on `full_o`, in the cycle after a queue reaches three entries. After that it shows as stores that were accepted or dropped against expectation. The bench applies every combination of pipe valids and target displays. It checks every display output, every read and the stall on each cycle against an arithmetic reference queue.

// File: rtl/mmio_q_pkg.sv
package mmio_q_pkg;
  // Which pipe supplies the first enqueue slot of a display queue
  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } slot_sel_e;
endpackage

// File: rtl/mmio_store_steer.sv
module mmio_store_steer
  import mmio_q_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             a_valid_i,
  input  logic [DEV_W-1:0] a_dev_i,
  input  logic             b_valid_i,
  input  logic [DEV_W-1:0] b_dev_i,
  output logic [1:0]       push_n_o   [NUM_DEV],
  output slot_sel_e        first_sel_o[NUM_DEV]
);
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit_a, hit_b;
    assign hit_a = accept_i && a_valid_i && (a_dev_i == DEV_W'(d));
    assign hit_b = accept_i && b_valid_i && (b_dev_i == DEV_W'(d));
    assign push_n_o[d]    = {1'b0, hit_a} + {1'b0, hit_b};
    assign first_sel_o[d] = hit_a ? SEL_A : SEL_B;

    // R2: a paired push always places pipe A first
    assert_pair_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_n_o[d] == 2'd2) |-> (first_sel_o[d] == SEL_A));
    // R7: nothing is steered while the pipes are stalled
    assert_stall_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !accept_i |-> (push_n_o[d] == 2'd0));
  end
endmodule

// File: rtl/mmio_dev_queue.sv
module mmio_dev_queue
  import mmio_q_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        push_n_i,
  input  slot_sel_e         first_sel_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [CW-1:0]     count_o,
  output logic [DATA_W-1:0] youngest_o,
  output logic [DATA_W-1:0] dev_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]     count_q;
  logic [DATA_W-1:0] dev_q;
  logic [DATA_W-1:0] slot0_data;
  logic              pop;

  assign slot0_data = (first_sel_i == SEL_A) ? a_data_i : b_data_i;
  assign pop        = (count_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      dev_q    <= '0;
    end else begin
      if (push_n_i != 2'd0) mem_q[wr_ptr_q] <= slot0_data;
      if (push_n_i == 2'd2) mem_q[wr_ptr_q + PW'(1)] <= b_data_i;
      wr_ptr_q <= wr_ptr_q + PW'(push_n_i);
      if (pop) begin
        dev_q    <= mem_q[rd_ptr_q];
        rd_ptr_q <= rd_ptr_q + PW'(1);
      end
      count_q <= count_q + CW'(push_n_i) - CW'(pop);
    end
  end

  assign count_o    = count_q;
  assign youngest_o = mem_q[wr_ptr_q - PW'(1)];
  assign dev_data_o = dev_q;

  // R6: pushes only arrive while at least two slots are free
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_n_i != 2'd0) |-> (count_q <= CW'(DEPTH - 2)));
  // R3: without pushes, a non-empty queue shrinks by exactly one
  assert_drain_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != '0 && push_n_i == 2'd0) |=> (count_q == $past(count_q) - CW'(1)));
  // R3: an empty queue leaves the display register alone
  assert_empty_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |=> $stable(dev_q));
endmodule

// File: rtl/mmio_store_queue.sv
module mmio_store_queue
  import mmio_q_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      st_a_valid_i,
  input  logic [DEV_W-1:0]          st_a_dev_i,
  input  logic [DATA_W-1:0]         st_a_data_i,
  input  logic                      st_b_valid_i,
  input  logic [DEV_W-1:0]          st_b_dev_i,
  input  logic [DATA_W-1:0]         st_b_data_i,
  input  logic [DEV_W-1:0]          rd_dev_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic                      full_o,
  output logic [NUM_DEV*DATA_W-1:0] dev_data_o
);
  logic [1:0]        push_n   [NUM_DEV];
  slot_sel_e         first_sel[NUM_DEV];
  logic [CW-1:0]     count    [NUM_DEV];
  logic [DATA_W-1:0] youngest [NUM_DEV];
  logic [DATA_W-1:0] dev_val  [NUM_DEV];
  logic [NUM_DEV-1:0] tight;

  mmio_store_steer #(.NUM_DEV(NUM_DEV)) u_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (!full_o),
    .a_valid_i  (st_a_valid_i),
    .a_dev_i    (st_a_dev_i),
    .b_valid_i  (st_b_valid_i),
    .b_dev_i    (st_b_dev_i),
    .push_n_o   (push_n),
    .first_sel_o(first_sel)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_q
    mmio_dev_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_n_i   (push_n[d]),
      .first_sel_i(first_sel[d]),
      .a_data_i   (st_a_data_i),
      .b_data_i   (st_b_data_i),
      .count_o    (count[d]),
      .youngest_o (youngest[d]),
      .dev_data_o (dev_val[d])
    );
    assign tight[d] = (count[d] > CW'(DEPTH - 2));
    assign dev_data_o[d*DATA_W +: DATA_W] = dev_val[d];
  end

  assign full_o = |tight;

  always_comb begin
    rd_data_o = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (rd_dev_i == DEV_W'(d))
        rd_data_o = (count[d] != '0) ? youngest[d] : dev_val[d];
    end
  end

  // R4: an idle display reads back its register
  assert_read_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count[rd_dev_i] == '0) |-> (rd_data_o == dev_val[rd_dev_i]));
  // R6: occupancy never exceeds depth
  assert_depth_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count[rd_dev_i] <= CW'(DEPTH)));
endmodule

// File: tb/tb_mmio_store_queue.sv
`timescale 1ns/1ps
module tb_mmio_store_queue;
  localparam int NUM_DEV = 4;
  localparam int DATA_W  = 32;
  localparam int DEPTH   = 4;
  localparam int DEV_W   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic st_a_valid_i = 1'b0, st_b_valid_i = 1'b0;
  logic [DEV_W-1:0] st_a_dev_i = '0, st_b_dev_i = '0, rd_dev_i = '0;
  logic [DATA_W-1:0] st_a_data_i = '0, st_b_data_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic full_o;
  logic [NUM_DEV*DATA_W-1:0] dev_data_o;

  always #2 clk = ~clk;

  mmio_store_queue #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_a_valid_i(st_a_valid_i), .st_a_dev_i(st_a_dev_i), .st_a_data_i(st_a_data_i),
    .st_b_valid_i(st_b_valid_i), .st_b_dev_i(st_b_dev_i), .st_b_data_i(st_b_data_i),
    .rd_dev_i(rd_dev_i), .rd_data_o(rd_data_o), .full_o(full_o), .dev_data_o(dev_data_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  logic [DATA_W-1:0] m_q [NUM_DEV][8];
  int                m_cnt [NUM_DEV];
  logic [DATA_W-1:0] m_reg [NUM_DEV];
  int seq = 0;

  task automatic check(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit model_full();
    for (int d = 0; d < NUM_DEV; d++) if (m_cnt[d] > DEPTH - 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_outputs(input string tag);
    for (int d = 0; d < NUM_DEV; d++) begin
      logic [DATA_W-1:0] er;
      rd_dev_i = DEV_W'(d);
      #0.1;
      er = (m_cnt[d] != 0) ? m_q[d][m_cnt[d]-1] : m_reg[d];
      check(rd_data_o == er, {tag, " R4 read"}, rd_data_o, er);
      check(dev_data_o[d*DATA_W +: DATA_W] == m_reg[d], {tag, " R3 display"},
            dev_data_o[d*DATA_W +: DATA_W], m_reg[d]);
    end
  endtask

  task automatic step(input bit va, input int da, input bit vb, input int db, input string tag);
    bit f;
    logic [DATA_W-1:0] xa, xb;
    @(negedge clk);
    seq++;
    xa = 32'hA000_0000 + DATA_W'(seq * 3);
    xb = 32'hB000_0000 + DATA_W'(seq * 5);
    st_a_valid_i = va; st_a_dev_i = DEV_W'(da); st_a_data_i = xa;
    st_b_valid_i = vb; st_b_dev_i = DEV_W'(db); st_b_data_i = xb;
    f = model_full();
    #0.1;
    check(full_o == f, "R6 full", DATA_W'(full_o), DATA_W'(f));
    @(posedge clk);
    #1;
    st_a_valid_i = 1'b0; st_b_valid_i = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (m_cnt[d] > 0) begin
        m_reg[d] = m_q[d][0];
        for (int i = 0; i < 7; i++) m_q[d][i] = m_q[d][i+1];
        m_cnt[d]--;
      end
      if (!f && va && da == d) begin m_q[d][m_cnt[d]] = xa; m_cnt[d]++; end
      if (!f && vb && db == d) begin m_q[d][m_cnt[d]] = xb; m_cnt[d]++; end
    end
    check_outputs(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NUM_DEV; d++) begin m_cnt[d] = 0; m_reg[d] = '0; end
    #9 rst_ni = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(full_o == 1'b0, "R8 full", DATA_W'(full_o), '0);
    check(dev_data_o == '0, "R8 displays", dev_data_o[DATA_W-1:0], '0);
    check_outputs("R8");

    // full sweep of valids and targets
    for (int va = 0; va < 2; va++)
      for (int vb = 0; vb < 2; vb++)
        for (int da = 0; da < NUM_DEV; da++)
          for (int db = 0; db < NUM_DEV; db++) begin
            string t;
            if (va == 1 && vb == 1 && da == db) t = "R2";
            else if (va == 1 && vb == 1) t = "R5";
            else t = "R1";
            step(va[0], da, vb[0], db, t);
            for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b0, 0, "R3");
          end

    // back-to-back pairs to one display, then stores while stalled (R7)
    for (int k = 0; k < 6; k++) step(1'b1, 2, 1'b1, 2, "R7");
    for (int k = 0; k < 3; k++) step(1'b1, 1, 1'b1, 3, "R7");
    for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b0, 0, "R3");
    // overlapping traffic to separate displays (R5)
    for (int k = 0; k < 8; k++) step(1'b1, k % 4, 1'b1, (k + 1) % 4, "R5");
    for (int k = 0; k < 6; k++) step(1'b0, 0, 1'b0, 0, "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule